// File: doc/BRIEF.md
# 1-Wire ROM Command Processor

This block is the network layer of a single-wire slave. It runs after every bus reset and presence handshake. The bit-level front end gives it one strobe per master write slot, carrying the bit value, and one strobe per master read slot. The block returns the level the slave releases or pulls on the line through `rd_bit`. It first collects an 8-bit ROM function command, least significant bit first. It then carries that command out against a 64-bit identity register. The identity holds the family code in bits 7:0, the serial number in bits 55:8 and the check byte in bits 63:56, and it is always sent bit 0 first.

The block supports six commands: reading the identity, matching it against the master's 64 bits, the three-slot search elimination, skipping the identity exchange, rewriting the identity, and locking it for good. Locking takes effect only when a blocking strobe follows the lock command. The strobe stands in for the high-voltage pulse. A successful command raises `selected`, which hands the bus to the memory function layer. A failed command leaves the block quiet until the next bus reset. A bus reset never clears the lock.

Top module: `owr_rom_proc`

## Requirements
- R1: After `rst`, `selected` is 0 and `rd_bit` is 1. Write and read slots have no effect until `reset_detected` has been seen.
- R2: `reset_detected` sends the block from any state back to collecting a command byte and clears `selected`. It keeps the identity and the lock.
- R3: The command is taken from 8 write slots, bit 0 first. Any code other than 33h, 55h, F0h, CCh, 3Ch and 35h makes the block wait for a bus reset.
- R4: Read ROM (33h): read slot i (0..63) returns identity bit i, so the family byte (bits 7:0) comes first and the check byte (bits 63:56) comes last. `selected` rises after the 64th slot.
- R5: Match ROM (55h): 64 write slots are compared with identity bits 0..63. A full match raises `selected` after the 64th slot. Any differing bit drops the block until the next bus reset.
- R6: Search ROM (F0h): for each bit i, the first read slot returns bit i, the second read slot returns its complement, and the following write slot carries the master's direction. A direction that differs from bit i drops the block. Completing bit 63 raises `selected`.
- R7: Skip ROM (CCh) raises `selected` right after the 8th command bit. `selected` holds until `reset_detected`.
- R8: Write ROM (3Ch) with the lock clear takes 64 write slots, bit 0 first, and replaces the identity at the 64th slot. It then waits for a bus reset with `selected` at 0. A write cut short by `reset_detected` leaves the identity unchanged.
- R9: A `blocking_pulse` strobe that follows Block ROM (35h) sets the lock. After that, Write ROM is ignored and leaves the identity unchanged, even across bus resets.
- R10: Block ROM that ends in a bus reset without a strobe does not lock. A `blocking_pulse` in any other state does not lock either.
- R11: While the block is waiting for a bus reset, read slots return 1 and write slots change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the default identity and clears the lock |
| reset_detected | input | 1 | One-cycle strobe: bus reset and presence done |
| slot_wr | input | 1 | One-cycle strobe: master write slot received |
| wr_bit | input | 1 | Bit value of the write slot |
| slot_rd | input | 1 | One-cycle strobe: master read slot completed |
| blocking_pulse | input | 1 | One-cycle strobe: identity blocking pulse seen |
| rd_bit | output | 1 | Level the slave presents in the current or next read slot (1 = released) |
| selected | output | 1 | Device addressed; memory function layer owns the bus |

## Verification
Every strobe is consumed on the rising edge where it is high. `rd_bit` and `selected` are decoded directly from the state registers, so each result is due in the same cycle as that edge, with no further latency. The bench drives each strobe for exactly one cycle, starting at a falling edge. It reads `rd_bit` at the falling edge before it raises a read strobe, so it sees the level presented for that slot. It reads the outcome of a write slot at the falling edge after the consuming rising edge. The identity and the lock are never probed directly; they are observed through later Read ROM sequences.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_WRITE  = 8'h3C;
    localparam logic [CMD_W-1:0] OP_BLOCK  = 8'h35;

    typedef enum logic [3:0] {
        ST_WAIT,      // quiet until bus reset
        ST_CMD,       // collecting command byte
        ST_READ,      // sending identity
        ST_MATCH,     // comparing master bits
        ST_SRCH_BIT,  // search: send true bit
        ST_SRCH_CMP,  // search: send complement
        ST_SRCH_DIR,  // search: take master direction
        ST_WRITE,     // receiving new identity
        ST_BLOCK,     // awaiting blocking strobe
        ST_SEL        // addressed
    } rom_state_e;

    function automatic rom_state_e decode_op(logic [CMD_W-1:0] op, logic locked);
        rom_state_e nxt;
        case (op)
            OP_READ:   nxt = ST_READ;
            OP_MATCH:  nxt = ST_MATCH;
            OP_SEARCH: nxt = ST_SRCH_BIT;
            OP_SKIP:   nxt = ST_SEL;
            OP_WRITE:  nxt = locked ? ST_WAIT : ST_WRITE;
            OP_BLOCK:  nxt = ST_BLOCK;
            default:   nxt = ST_WAIT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/owr_shift_in.sv
module owr_shift_in #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data_nxt
);
    logic [W-1:0] data_q;

    // LSB-first: newest bit enters at the top and walks down
    assign data_nxt = {bit_in, data_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || clear)
            data_q <= '0;
        else if (shift_en)
            data_q <= data_nxt;
    end
endmodule

// File: rtl/owr_id_store.sv
module owr_id_store #(
    parameter int              ID_W       = 64,
    parameter logic [ID_W-1:0] DEFAULT_ID = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic [ID_W-1:0] load_val,
    input  logic            lock_set,
    output logic [ID_W-1:0] id_q,
    output logic            locked_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            id_q     <= DEFAULT_ID;
            locked_q <= 1'b0;
        end else begin
            if (load_en && !locked_q)
                id_q <= load_val;
            if (lock_set)
                locked_q <= 1'b1;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);  // R9

    AST_ID_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(id_q));  // R9
endmodule

// File: rtl/owr_rom_fsm.sv
module owr_rom_fsm
    import owr_rom_pkg::*;
#(
    parameter int ID_W  = 64,
    localparam int IDX_W = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_detected,
    input  logic             slot_wr,
    input  logic             wr_bit,
    input  logic             slot_rd,
    input  logic             blocking_pulse,
    input  logic [ID_W-1:0]  id_q,
    input  logic             locked,
    input  logic [CMD_W-1:0] cmd_nxt,
    output logic             cmd_shift,
    output logic             stg_shift,
    output logic             shift_clear,
    output logic             id_load,
    output logic             lock_set,
    output logic             rd_bit,
    output logic             selected
);
    rom_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             cur_bit;
    logic             last_id_bit;
    logic             last_cmd_bit;

    assign cur_bit      = id_q[idx_q];
    assign last_id_bit  = (idx_q == IDX_W'(ID_W - 1));
    assign last_cmd_bit = (idx_q == IDX_W'(CMD_W - 1));

    assign shift_clear = reset_detected;
    assign cmd_shift   = (state_q == ST_CMD)   && slot_wr && !reset_detected;
    assign stg_shift   = (state_q == ST_WRITE) && slot_wr && !reset_detected;
    assign id_load     = stg_shift && last_id_bit;
    assign lock_set    = (state_q == ST_BLOCK) && blocking_pulse && !reset_detected;
    assign selected    = (state_q == ST_SEL);

    always_comb begin
        case (state_q)
            ST_READ, ST_SRCH_BIT: rd_bit = cur_bit;
            ST_SRCH_CMP:          rd_bit = ~cur_bit;
            default:              rd_bit = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (reset_detected) begin
            state_d = ST_CMD;
            idx_d   = '0;
        end else begin
            case (state_q)
                ST_CMD: if (slot_wr) begin
                    if (last_cmd_bit) begin
                        state_d = decode_op(cmd_nxt, locked);
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_READ: if (slot_rd) begin
                    if (last_id_bit) state_d = ST_SEL;
                    else             idx_d   = idx_q + 1'b1;
                end
                ST_MATCH: if (slot_wr) begin
                    if (wr_bit != cur_bit) state_d = ST_WAIT;
                    else if (last_id_bit)  state_d = ST_SEL;
                    else                   idx_d   = idx_q + 1'b1;
                end
                ST_SRCH_BIT: if (slot_rd) state_d = ST_SRCH_CMP;
                ST_SRCH_CMP: if (slot_rd) state_d = ST_SRCH_DIR;
                ST_SRCH_DIR: if (slot_wr) begin
                    if (wr_bit != cur_bit) state_d = ST_WAIT;
                    else if (last_id_bit)  state_d = ST_SEL;
                    else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = ST_SRCH_BIT;
                    end
                end
                ST_WRITE: if (slot_wr) begin
                    if (last_id_bit) state_d = ST_WAIT;
                    else             idx_d   = idx_q + 1'b1;
                end
                ST_BLOCK: if (blocking_pulse) state_d = ST_WAIT;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    AST_BUS_RESET_RESTART: assert property (@(posedge clk) disable iff (rst)
        reset_detected |=> (state_q == ST_CMD && idx_q == '0 && !selected));  // R2

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (selected && !reset_detected) |=> selected);  // R7

    AST_MATCH_DROP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MATCH && slot_wr && !reset_detected && wr_bit != id_q[idx_q])
        |=> (state_q == ST_WAIT));  // R5

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !reset_detected) |=> (state_q == ST_WAIT && rd_bit && !selected));  // R11

    AST_WRITE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |-> !locked);  // R9
endmodule

// File: rtl/owr_rom_proc.sv
module owr_rom_proc
    import owr_rom_pkg::*;
#(
    parameter int              ID_W       = 64,
    parameter logic [ID_W-1:0] DEFAULT_ID = 64'hD49E017BC35A662A
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_detected,
    input  logic slot_wr,
    input  logic wr_bit,
    input  logic slot_rd,
    input  logic blocking_pulse,
    output logic rd_bit,
    output logic selected
);
    logic [CMD_W-1:0] cmd_nxt;
    logic [ID_W-1:0]  stg_nxt;
    logic [ID_W-1:0]  id_q;
    logic             locked;
    logic             cmd_shift, stg_shift, shift_clear, id_load, lock_set;

    owr_shift_in #(.W(CMD_W)) u_cmd_sr (
        .clk(clk), .rst(rst), .clear(shift_clear), .shift_en(cmd_shift),
        .bit_in(wr_bit), .data_nxt(cmd_nxt)
    );

    owr_shift_in #(.W(ID_W)) u_stage_sr (
        .clk(clk), .rst(rst), .clear(shift_clear), .shift_en(stg_shift),
        .bit_in(wr_bit), .data_nxt(stg_nxt)
    );

    owr_id_store #(.ID_W(ID_W), .DEFAULT_ID(DEFAULT_ID)) u_id (
        .clk(clk), .rst(rst), .load_en(id_load), .load_val(stg_nxt),
        .lock_set(lock_set), .id_q(id_q), .locked_q(locked)
    );

    owr_rom_fsm #(.ID_W(ID_W)) u_fsm (
        .clk(clk), .rst(rst), .reset_detected(reset_detected),
        .slot_wr(slot_wr), .wr_bit(wr_bit), .slot_rd(slot_rd),
        .blocking_pulse(blocking_pulse), .id_q(id_q), .locked(locked),
        .cmd_nxt(cmd_nxt), .cmd_shift(cmd_shift), .stg_shift(stg_shift),
        .shift_clear(shift_clear), .id_load(id_load), .lock_set(lock_set),
        .rd_bit(rd_bit), .selected(selected)
    );
endmodule

// File: tb/owr_rom_proc_tb.sv
module owr_rom_proc_tb_top;
    localparam logic [63:0] ID0 = 64'hD49E017BC35A662A;
    localparam logic [63:0] ID2 = 64'h5BC4E0193A7D0F81;
    localparam logic [63:0] ID3 = 64'h0F1E2D3C4B5A6978;
    localparam logic [63:0] ID4 = 64'hFFEEDDCCBBAA9988;

    // {command[9:2], expect selected[1], expect rd_bit shows id bit 0 [0]}
    localparam logic [9:0] VEC [8] = '{
        {8'hCC, 1'b1, 1'b0},
        {8'h33, 1'b0, 1'b1},
        {8'h55, 1'b0, 1'b0},
        {8'hF0, 1'b0, 1'b1},
        {8'h3C, 1'b0, 1'b0},
        {8'h35, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b0},
        {8'hFF, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_detected = 1'b0;
    logic slot_wr = 1'b0;
    logic wr_bit = 1'b0;
    logic slot_rd = 1'b0;
    logic blocking_pulse = 1'b0;
    logic rd_bit, selected;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    owr_rom_proc dut_i (
        .clk(clk), .rst(rst), .reset_detected(reset_detected),
        .slot_wr(slot_wr), .wr_bit(wr_bit), .slot_rd(slot_rd),
        .blocking_pulse(blocking_pulse), .rd_bit(rd_bit), .selected(selected)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_reset();
        @(negedge clk); reset_detected = 1'b1;
        @(negedge clk); reset_detected = 1'b0;
    endtask

    task automatic wbit(input logic b);
        @(negedge clk); slot_wr = 1'b1; wr_bit = b;
        @(negedge clk); slot_wr = 1'b0;
    endtask

    task automatic rbit(output logic b);
        @(negedge clk); b = rd_bit; slot_rd = 1'b1;
        @(negedge clk); slot_rd = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask

    task automatic send_id(input logic [63:0] v);
        for (int i = 0; i < 64; i++) wbit(v[i]);
    endtask

    task automatic read_id(output logic [63:0] v);
        logic b;
        for (int i = 0; i < 64; i++) begin
            rbit(b);
            v[i] = b;
        end
    endtask

    task automatic fetch_id(output logic [63:0] v);
        bus_reset();
        send_byte(8'h33);
        read_id(v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] got;
        logic b, t, c;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 selected after rst", 64'(selected), 64'd0);
        check("R1 rd_bit after rst", 64'(rd_bit), 64'd1);
        // R1: Skip code before any bus reset has no effect
        send_byte(8'hCC);
        check("R1 no select before bus reset", 64'(selected), 64'd0);

        // R3: table of command codes
        for (int i = 0; i < 8; i++) begin
            bus_reset();
            send_byte(VEC[i][9:2]);
            check($sformatf("R3 cmd %h selected", VEC[i][9:2]), 64'(selected), 64'(VEC[i][1]));
            check($sformatf("R3 cmd %h rd_bit", VEC[i][9:2]), 64'(rd_bit),
                  VEC[i][0] ? 64'(ID0[0]) : 64'd1);
        end

        // R4: full Read ROM
        bus_reset();
        send_byte(8'h33);
        read_id(got);
        check("R4 read identity", got, ID0);
        check("R4 selected after read", 64'(selected), 64'd1);

        // R2: bus reset clears selection
        bus_reset();
        check("R2 selection cleared", 64'(selected), 64'd0);
        send_byte(8'hCC);
        check("R7 skip selects", 64'(selected), 64'd1);
        repeat (5) @(negedge clk);
        check("R7 selection holds", 64'(selected), 64'd1);

        // R5: matching
        bus_reset();
        send_byte(8'h55);
        send_id(ID0);
        check("R5 full match selects", 64'(selected), 64'd1);
        bus_reset();
        send_byte(8'h55);
        send_id(ID0 ^ (64'd1 << 40));
        check("R5 mismatch drops", 64'(selected), 64'd0);
        rbit(b);
        check("R11 read after drop", 64'(b), 64'd1);

        // R6: full search
        bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rbit(t);
            rbit(c);
            check($sformatf("R6 search bit %0d", i), {62'd0, t, c}, {62'd0, ID0[i], ~ID0[i]});
            wbit(ID0[i]);
        end
        check("R6 search selects", 64'(selected), 64'd1);

        // R6/R11: search with wrong direction at bit 3
        bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 4; i++) begin
            rbit(t);
            rbit(c);
            wbit(i == 3 ? ~ID0[i] : ID0[i]);
        end
        rbit(b);
        check("R6 dropped search rd_bit", 64'(b), 64'd1);
        wbit(1'b0);
        rbit(b);
        check("R11 quiet after drop", {62'd0, b, selected}, {62'd0, 1'b1, 1'b0});

        // R8: rewrite identity
        bus_reset();
        send_byte(8'h3C);
        send_id(ID2);
        check("R8 not selected after write", 64'(selected), 64'd0);
        fetch_id(got);
        check("R8 new identity", got, ID2);
        // R8: aborted write
        bus_reset();
        send_byte(8'h3C);
        for (int i = 0; i < 20; i++) wbit(ID4[i]);
        fetch_id(got);
        check("R8 partial write keeps identity", got, ID2);

        // R10: block without strobe, then stray strobe while selected
        bus_reset();
        send_byte(8'h35);
        bus_reset();
        send_byte(8'hCC);
        @(negedge clk); blocking_pulse = 1'b1;
        @(negedge clk); blocking_pulse = 1'b0;
        bus_reset();
        send_byte(8'h3C);
        send_id(ID3);
        fetch_id(got);
        check("R10 no lock without proper strobe", got, ID3);

        // R9: lock, then write ignored across bus resets
        bus_reset();
        send_byte(8'h35);
        @(negedge clk); blocking_pulse = 1'b1;
        @(negedge clk); blocking_pulse = 1'b0;
        bus_reset();
        send_byte(8'h3C);
        check("R9 locked write idles", {62'd0, rd_bit, selected}, {62'd0, 1'b1, 1'b0});
        send_id(ID4);
        fetch_id(got);
        check("R9 identity unchanged", got, ID3);
        bus_reset();
        bus_reset();
        send_byte(8'h3C);
        send_id(ID4);
        fetch_id(got);
        check("R9 lock survives bus reset", got, ID3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule